// File: doc/BRIEF.md
# Trace FIFO Stall and Overflow Monitor

This block sits beside a byte-wide trace FIFO and decides two things every cycle. The first is whether the processor should be asked to stall because free space in the FIFO has fallen below a programmed threshold. The second is whether incoming trace packets may be written into the FIFO. It also keeps a sticky flag for an overflow that the trace stream has not yet reported.

The stall request is registered. It reflects the free-byte count and controls from the previous clock edge, and it stays low whenever the stall-enable control is 0. The write-permission side is a two-state machine. In `ST_RUN` packets are accepted. An overflow event moves it to `ST_DROP` (transition *overflow*), where packets are discarded. A drained indication with no new overflow in the same cycle returns it to `ST_RUN` (transition *resume*), so trace restarts cleanly from an empty FIFO. An overflow seen while in `ST_DROP` keeps it there (transition *re-overflow*).

The untraced-overflow flag is set by any overflow event. It is cleared by a trace restart, by the power-down control, or by an acknowledge that the overflow marker has been emitted. When a set and a clear meet in the same cycle, the set wins. The programming-mode control has no effect on the flag.

Top module: `trace_stall_monitor`

## Requirements
- R1: With stall enabled, `stall_req` is 1 in the cycle after an edge at which `free_bytes` was strictly less than `stall_level` (level 15 with 14 free bytes gives 1).
- R2: With stall enabled, `stall_req` is 0 after an edge at which `free_bytes` was equal to or greater than `stall_level`; a level of 0 never stalls.
- R3: When `stall_en` was 0 at the last edge, `stall_req` is 0 whatever the free-byte count.
- R4: After reset `stall_req` is 0, `ovf_untraced` is 0 and `pkt_accept` is 1 (state `ST_RUN`).
- R5: An overflow event makes `pkt_accept` 0 from the next cycle. It stays 0 until an edge at which `fifo_drained` is 1 and no overflow occurs, and it is 1 after that edge.
- R6: An overflow event arriving while dropping, even together with `fifo_drained`, keeps `pkt_accept` at 0.
- R7: An overflow event sets `ovf_untraced` at the next edge, and the flag stays set while no clear input is asserted.
- R8: Any of `trace_restart`, `power_down` or `ovf_marker_ack` being 1 at an edge with no overflow event clears `ovf_untraced`.
- R9: Setting or clearing `prog_mode` leaves `ovf_untraced` unchanged.
- R10: When an overflow event and a clear input are 1 at the same edge, `ovf_untraced` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| free_bytes | input | FREE_W | Free bytes currently in the trace FIFO |
| stall_level | input | THR_W | Stall threshold; stall when free space is below it |
| stall_en | input | 1 | Enables the stall request |
| ovf_evt | input | 1 | FIFO overflow event, one cycle per event |
| fifo_drained | input | 1 | FIFO has emptied after an overflow |
| trace_restart | input | 1 | Trace is being restarted; clears the flag |
| power_down | input | 1 | Power-down control is 1; clears the flag |
| ovf_marker_ack | input | 1 | Overflow marker has been written to the trace stream |
| prog_mode | input | 1 | Programming-mode control; does not touch the flag |
| stall_req | output | 1 | Registered stall request to the processor |
| pkt_accept | output | 1 | Packets may be written into the FIFO |
| ovf_untraced | output | 1 | Sticky flag for an overflow not yet reported |

## Verification
The threshold comparison is probed at equality, one below, zero and full scale. A design using less-or-equal would stall at equality, and one with a zero-level bug would stall on an empty FIFO. The bench checks that acceptance stays low until drained and that an overflow coinciding with drained keeps dropping; a design that let drained win would resume with a corrupt FIFO. Each clear source is exercised separately, a set and a clear are applied together, and programming mode is toggled under a set flag. These catch a missing clear path, clear-wins priority, or a flag wired to programming mode.

// File: rtl/trace_mon_pkg.sv
package trace_mon_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_DROP = 1'b1
    } drop_state_e;
endpackage

// File: rtl/stall_gen.sv
module stall_gen #(
    parameter int FREE_W = 10,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [THR_W-1:0]  stall_level,
    input  logic              stall_en,
    output logic              stall_req
);
    localparam int CMP_W = (FREE_W > THR_W) ? FREE_W : THR_W;

    logic [CMP_W-1:0] free_ext;
    logic [CMP_W-1:0] level_ext;
    logic             below_level;

    always_comb begin
        free_ext    = CMP_W'(free_bytes);
        level_ext   = CMP_W'(stall_level);
        below_level = free_ext < level_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stall_req <= 1'b0;
        else        stall_req <= stall_en & below_level;
    end

    // R1
    stall_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && (free_ext < level_ext)) |=> stall_req);
    // R2
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_ext >= level_ext) |=> !stall_req);
    // R3
    stall_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_en |=> !stall_req);
endmodule

// File: rtl/ovf_tracker.sv
module ovf_tracker
    import trace_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic fifo_drained,
    input  logic trace_restart,
    input  logic power_down,
    input  logic ovf_marker_ack,
    input  logic prog_mode,
    output logic pkt_accept,
    output logic ovf_untraced
);
    drop_state_e state, state_nxt;
    logic        clr_any;

    always_comb clr_any = trace_restart | power_down | ovf_marker_ack;

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:  if (ovf_evt) state_nxt = ST_DROP;
            ST_DROP: if (fifo_drained && !ovf_evt) state_nxt = ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_RUN:  pkt_accept = 1'b1;
            ST_DROP: pkt_accept = 1'b0;
            default: pkt_accept = 1'b1;
        endcase
    end

    // sticky flag; programming mode intentionally not a clear source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_untraced <= 1'b0;
        else if (ovf_evt) ovf_untraced <= 1'b1;
        else if (clr_any) ovf_untraced <= 1'b0;
    end

    // R5
    drop_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> !pkt_accept);
    // R5
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_accept && fifo_drained && !ovf_evt) |=> pkt_accept);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_untraced);
    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_evt && clr_any) |=> !ovf_untraced);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_untraced && !clr_any && (prog_mode || !prog_mode)) |=> ovf_untraced);
endmodule

// File: rtl/trace_stall_monitor.sv
module trace_stall_monitor #(
    parameter int FREE_W = 10,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [THR_W-1:0]  stall_level,
    input  logic              stall_en,
    input  logic              ovf_evt,
    input  logic              fifo_drained,
    input  logic              trace_restart,
    input  logic              power_down,
    input  logic              ovf_marker_ack,
    input  logic              prog_mode,
    output logic              stall_req,
    output logic              pkt_accept,
    output logic              ovf_untraced
);
    stall_gen #(.FREE_W(FREE_W), .THR_W(THR_W)) u_stall (
        .clk        (clk),
        .rst_n      (rst_n),
        .free_bytes (free_bytes),
        .stall_level(stall_level),
        .stall_en   (stall_en),
        .stall_req  (stall_req)
    );

    ovf_tracker u_ovf (
        .clk           (clk),
        .rst_n         (rst_n),
        .ovf_evt       (ovf_evt),
        .fifo_drained  (fifo_drained),
        .trace_restart (trace_restart),
        .power_down    (power_down),
        .ovf_marker_ack(ovf_marker_ack),
        .prog_mode     (prog_mode),
        .pkt_accept    (pkt_accept),
        .ovf_untraced  (ovf_untraced)
    );
endmodule

// File: tb/trace_stall_monitor_tb.sv
`timescale 1ns/1ps
module trace_stall_monitor_tb;
    localparam int FREE_W = 10;
    localparam int THR_W  = 8;
    localparam int NV     = 8;
    // {stall_en, stall_level, free_bytes, expected stall_req}
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 8'd15,  10'd14,  1'b1},
        {1'b1, 8'd15,  10'd15,  1'b0},
        {1'b1, 8'd15,  10'd16,  1'b0},
        {1'b1, 8'd0,   10'd0,   1'b0},
        {1'b1, 8'd255, 10'd254, 1'b1},
        {1'b1, 8'd255, 10'd300, 1'b0},
        {1'b0, 8'd255, 10'd0,   1'b0},
        {1'b1, 8'd1,   10'd0,   1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [FREE_W-1:0] free_bytes = '0;
    logic [THR_W-1:0]  stall_level = '0;
    logic stall_en = 0, ovf_evt = 0, fifo_drained = 0, trace_restart = 0;
    logic power_down = 0, ovf_marker_ack = 0, prog_mode = 0;
    logic stall_req, pkt_accept, ovf_untraced;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trace_stall_monitor #(.FREE_W(FREE_W), .THR_W(THR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .free_bytes(free_bytes), .stall_level(stall_level),
        .stall_en(stall_en), .ovf_evt(ovf_evt), .fifo_drained(fifo_drained),
        .trace_restart(trace_restart), .power_down(power_down),
        .ovf_marker_ack(ovf_marker_ack), .prog_mode(prog_mode),
        .stall_req(stall_req), .pkt_accept(pkt_accept), .ovf_untraced(ovf_untraced)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R4 reset state
        check("R4 stall", stall_req, 1'b0);
        check("R4 flag", ovf_untraced, 1'b0);
        check("R4 accept", pkt_accept, 1'b1);
        rst_n = 1'b1;
        tick();

        // R1 R2 R3 threshold table
        for (int i = 0; i < NV; i++) begin
            stall_en    = VEC[i][19];
            stall_level = VEC[i][18:11];
            free_bytes  = VEC[i][10:1];
            tick();
            check(VEC[i][19] ? (VEC[i][0] ? "R1 below" : "R2 not below") : "R3 disabled",
                  stall_req, VEC[i][0]);
        end
        stall_en = 1'b0;
        free_bytes = '0;
        tick();
        check("R3 disabled empty", stall_req, 1'b0);

        // R5 R7 overflow and drain
        ovf_evt = 1'b1; tick();
        check("R5 drop", pkt_accept, 1'b0);
        check("R7 set", ovf_untraced, 1'b1);
        ovf_evt = 1'b0; tick();
        check("R5 still drop", pkt_accept, 1'b0);
        check("R7 sticky", ovf_untraced, 1'b1);
        fifo_drained = 1'b1; tick();
        check("R5 resume", pkt_accept, 1'b1);
        fifo_drained = 1'b0;

        // R9 programming mode ignored
        prog_mode = 1'b1; tick();
        check("R9 prog set", ovf_untraced, 1'b1);
        prog_mode = 1'b0; tick();
        check("R9 prog clear", ovf_untraced, 1'b1);

        // R8 restart clears
        trace_restart = 1'b1; tick();
        check("R8 restart", ovf_untraced, 1'b0);
        trace_restart = 1'b0;
        // R8 power-down clears
        ovf_evt = 1'b1; tick();
        ovf_evt = 1'b0; power_down = 1'b1; tick();
        check("R8 power down", ovf_untraced, 1'b0);
        power_down = 1'b0;
        // R8 marker ack clears
        ovf_evt = 1'b1; tick();
        ovf_evt = 1'b0; ovf_marker_ack = 1'b1; tick();
        check("R8 marker ack", ovf_untraced, 1'b0);
        ovf_marker_ack = 1'b0;
        fifo_drained = 1'b1; tick();
        check("R5 resume again", pkt_accept, 1'b1);
        fifo_drained = 1'b0;

        // R6 overflow with drained while dropping
        ovf_evt = 1'b1; tick();
        fifo_drained = 1'b1; tick();
        check("R6 reoverflow", pkt_accept, 1'b0);
        ovf_evt = 1'b0; tick();
        check("R6 then resume", pkt_accept, 1'b1);
        fifo_drained = 1'b0;

        // R10 set wins over clear
        trace_restart = 1'b1; tick();
        check("R10 pre-clear", ovf_untraced, 1'b0);
        ovf_evt = 1'b1; tick();
        check("R10 set wins", ovf_untraced, 1'b1);
        ovf_evt = 1'b0; tick();
        check("R8 after", ovf_untraced, 1'b0);
        trace_restart = 1'b0;
        fifo_drained = 1'b1; tick();
        fifo_drained = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule